// File: doc/BRIEF.md
# TDM Channel Blocking Strobe Generator

This block produces a single blocking strobe for the transmit side of a time-division multiplexed backplane. It steps through each frame one bit time at a time, clocked by the backplane bit clock. A frame sync resynchronises it. Over every channel time, the strobe is held at the value of that channel's bit in a 32-bit mask. The mask is spread across four byte-wide registers, which a small write/read port loads.

Two frame formats are supported. The 32-slot format has 256 bit times: 32 channels of eight bits each. The 24-slot format has 193 bit times: a single framing bit comes first, then 24 channels of eight bits each. In the 24-slot format, bit 0 of the highest register no longer masks a channel. It selects whether the strobe is high during the framing bit.

Mask writes and a change of the mode input both take effect at the next frame start. As a result, every frame is generated from one coherent mask and one format.

Top module: `tdm_block_strobe`

## Requirements
- R1: After reset all four registers read 0, the frame format is the 32-slot format, and `blk_out` is low.
- R2: Registers sit at `addr` 0 to 3. A write with `wr_en` high lands at the clock edge. `rdata` is combinational on `addr` and returns the last value written to that register.
- R3: Channel c (1 to 32) is bit (c-1) mod 8 of register (c-1) div 8. Channel 1 is therefore bit 0 of register 0, and channel 32 is bit 7 of register 3.
- R4: With `mode_t1`=0 (32-slot format), bit times 8(c-1) to 8c-1 of the frame belong to channel c. For each of them, `blk_out` equals that channel's mask bit.
- R5: With `mode_t1`=1 (24-slot format), bit time 0 is the framing bit. Bit times 8(c-1)+1 to 8c belong to channel c, for c from 1 to 24.
- R6: In the 24-slot format, `blk_out` during the framing bit equals bit 0 of register 3.
- R7: In the 24-slot format, bits 7:1 of register 3 have no effect on `blk_out`.
- R8: A clock edge that samples `fsync` high starts bit time 0 of a new frame, even in the middle of a frame. `blk_out` is registered. The value for the bit time started at an edge appears just after that edge.
- R9: A register write reaches `blk_out` only from the next frame start onward. A write on the same edge as a frame start waits for the frame after that one.
- R10: Without `fsync`, the position counter wraps to bit time 0 after the last bit time of the format: 255 in the 32-slot format, 192 in the 24-slot format.
- R11: The `mode_t1` value sampled at a frame start sets the format for that whole frame. A change in mid-frame waits for the next frame start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Backplane bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | Frame sync; high marks bit time 0 |
| mode_t1 | input | 1 | 1 = 24-slot plus framing bit, 0 = 32-slot |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| blk_out | output | 1 | Registered channel blocking strobe |

## Verification
The assertions assume the inputs change only between clock edges. They accept `fsync` at any bit time, but assume the format and the active mask can change only when a frame starts. That assumption is what lets the strobe be declared steady within a channel. The stimulus drives every input on the falling edge. It changes `mode_t1` and the registers both on frame boundaries and in mid-frame, and it places sync pulses both on time and early. The reference model in the bench applies its own frame-start rule to each of these cases, bit by bit.

// File: rtl/tdm_blk_pkg.sv
`timescale 1ns/1ps
package tdm_blk_pkg;

  localparam int REG_W    = 8;
  localparam int NUM_REGS = 4;
  localparam int CH_BITS  = 8;
  localparam int T1_CH    = 24;

  localparam int ADDR_W   = $clog2(NUM_REGS);
  localparam int MASK_W   = REG_W * NUM_REGS;
  localparam int E1_LEN   = MASK_W * CH_BITS;
  localparam int T1_LEN   = T1_CH * CH_BITS + 1;
  localparam int CNT_W    = $clog2(E1_LEN);
  localparam int CH_SHIFT = $clog2(CH_BITS);
  localparam int CHAN_W   = CNT_W - CH_SHIFT;
  localparam int FBIT_IDX = T1_CH;

  typedef enum logic {
    MODE_E1 = 1'b0,
    MODE_T1 = 1'b1
  } frame_mode_e;

  typedef logic [CNT_W-1:0]  pos_t;
  typedef logic [MASK_W-1:0] mask_t;

  // Last bit time of a frame in the given format.
  function automatic pos_t frame_last(input frame_mode_e mode);
    if (mode == MODE_T1) return pos_t'(T1_LEN - 1);
    return pos_t'(E1_LEN - 1);
  endfunction

  // Position after pos when no sync arrives.
  function automatic pos_t next_pos(input pos_t pos, input frame_mode_e mode);
    if (pos == frame_last(mode)) return '0;
    return pos + 1'b1;
  endfunction

  // Offset of pos inside the channel area (the framing bit excluded).
  function automatic pos_t chan_offset(input pos_t pos, input frame_mode_e mode);
    if (mode == MODE_T1) return pos - 1'b1;
    return pos;
  endfunction

  // True where a channel or the framing bit begins.
  function automatic logic pos_is_start(input pos_t pos, input frame_mode_e mode);
    pos_t off;
    if (mode == MODE_T1 && pos == '0) return 1'b1;
    off = chan_offset(pos, mode);
    return off[CH_SHIFT-1:0] == '0;
  endfunction

  // Strobe level for a bit time under a given mask.
  function automatic logic strobe_value(input mask_t mask, input pos_t pos,
                                        input frame_mode_e mode);
    pos_t              off;
    logic [CHAN_W-1:0] ch;
    if (mode == MODE_T1 && pos == '0) return mask[FBIT_IDX];
    off = chan_offset(pos, mode);
    ch  = off[CNT_W-1:CH_SHIFT];
    return mask[ch];
  endfunction

endpackage

// File: rtl/tdm_mask_regs.sv
`timescale 1ns/1ps
module tdm_mask_regs
  import tdm_blk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output mask_t             shadow
);

  logic [REG_W-1:0] regq [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic hit;
    assign hit = wr_en && (addr == ADDR_W'(r));
    always_ff @(posedge clk) begin
      if (!rst_n)   regq[r] <= '0;
      else if (hit) regq[r] <= wdata;
    end
    assign shadow[r*REG_W +: REG_W] = regq[r];
  end

  assign rdata = regq[addr];

  // R2: a write is visible in the addressed register on the next cycle
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (regq[$past(addr)] == $past(wdata)));

endmodule

// File: rtl/tdm_bit_counter.sv
`timescale 1ns/1ps
module tdm_bit_counter
  import tdm_blk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fsync,
  input  frame_mode_e mode_in,
  output pos_t        pos_now,
  output frame_mode_e mode_now,
  output logic        frame_start,
  output logic        chan_start
);

  pos_t        pos_q;
  frame_mode_e mode_q;

  assign pos_now     = fsync ? '0 : next_pos(pos_q, mode_q);
  assign frame_start = (pos_now == '0);
  assign mode_now    = frame_start ? mode_in : mode_q;
  assign chan_start  = pos_is_start(pos_now, mode_now);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q  <= '0;
      mode_q <= MODE_E1;
    end else begin
      pos_q <= pos_now;
      if (frame_start) mode_q <= mode_in;
    end
  end

  // R8: a sampled sync restarts the frame at bit time 0
  p_sync_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> (pos_q == '0));

  // R10: position never leaves the frame of the current format
  p_pos_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= frame_last(mode_q));

  // R10: free-running wrap after the last bit time
  p_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!fsync && pos_q == frame_last(mode_q)) |=> (pos_q == '0));

  // R11: format only changes at a frame start
  p_mode_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(mode_q));

endmodule

// File: rtl/tdm_strobe_out.sv
`timescale 1ns/1ps
module tdm_strobe_out
  import tdm_blk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  mask_t       shadow,
  input  pos_t        pos_now,
  input  frame_mode_e mode_now,
  input  logic        frame_start,
  input  logic        chan_start,
  output logic        blk_out
);

  mask_t active_q;
  mask_t mask_now;
  logic  level_now;

  assign mask_now  = frame_start ? shadow : active_q;
  assign level_now = strobe_value(mask_now, pos_now, mode_now);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= '0;
      blk_out  <= 1'b0;
    end else begin
      if (frame_start) active_q <= shadow;
      blk_out <= level_now;
    end
  end

  // R9: the mask in use is held for the whole frame
  p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(active_q));

  // R4: the strobe does not move inside a channel time
  p_chan_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_start |=> $stable(blk_out));

  // R6: framing-bit level follows register 3 bit 0 at the frame start
  p_fbit_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && mode_now == MODE_T1) |=> (blk_out == $past(shadow[FBIT_IDX])));

endmodule

// File: rtl/tdm_block_strobe.sv
`timescale 1ns/1ps
module tdm_block_strobe
  import tdm_blk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic              mode_t1,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              blk_out
);

  mask_t       shadow;
  pos_t        pos_now;
  frame_mode_e mode_now;
  frame_mode_e mode_in;
  logic        frame_start;
  logic        chan_start;

  assign mode_in = frame_mode_e'(mode_t1);

  tdm_mask_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .rdata  (rdata),
    .shadow (shadow)
  );

  tdm_bit_counter u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .fsync       (fsync),
    .mode_in     (mode_in),
    .pos_now     (pos_now),
    .mode_now    (mode_now),
    .frame_start (frame_start),
    .chan_start  (chan_start)
  );

  tdm_strobe_out u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .shadow      (shadow),
    .pos_now     (pos_now),
    .mode_now    (mode_now),
    .frame_start (frame_start),
    .chan_start  (chan_start),
    .blk_out     (blk_out)
  );

endmodule

// File: tb/sim_tdm_block_strobe.sv
`timescale 1ns/1ps
module sim_tdm_block_strobe;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fsync = 1'b0;
  logic       mode_t1 = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       blk_out;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  int m_reg [4];
  int m_act [4];
  int m_idx = 0;
  int m_mode = 0;
  int m_last = 255;
  int exp_out = 0;

  tdm_block_strobe u0 (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .mode_t1(mode_t1),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .blk_out(blk_out)
  );

  always #4 clk = ~clk;

  // Expected strobe for a bit time, derived from R3..R6
  function automatic int ref_level(int idx);
    int c;
    if (m_mode == 1 && idx == 0) return m_act[3] & 1;
    c = (m_mode == 1) ? (idx - 1) / 8 : idx / 8;
    return (m_act[c / 8] >> (c % 8)) & 1;
  endfunction

  task automatic report(string req, int act, int expv);
    compared++;
    if (act != expv) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d (idx %0d)", req, act, expv, m_idx);
    end
  endtask

  // One bit time: check the previous edge, drive the next, advance the model.
  task automatic tick(bit fs, bit wr, int a, int d);
    @(negedge clk);
    report(cur_req, int'(blk_out), exp_out);
    fsync = fs; wr_en = wr; addr = 2'(a); wdata = 8'(d);
    if (fs || m_idx == m_last) m_idx = 0;
    else m_idx = m_idx + 1;
    if (m_idx == 0) begin
      for (int k = 0; k < 4; k++) m_act[k] = m_reg[k];
      m_mode = int'(mode_t1);
      m_last = (m_mode == 1) ? 192 : 255;
    end
    exp_out = ref_level(m_idx);
    if (wr) m_reg[a] = d;
  endtask

  task automatic read_chk(int a, string req);
    tick(0, 0, a, 0);
    #2;
    report(req, int'(rdata), m_reg[a]);
  endtask

  task automatic write4(int b0, int b1, int b2, int b3);
    tick(0, 1, 0, b0);
    tick(0, 1, 1, b1);
    tick(0, 1, 2, b2);
    tick(0, 1, 3, b3);
  endtask

  task automatic run_frame(int len);
    for (int i = 0; i < len; i++) tick(i == 0, 0, 0, 0);
  endtask

  initial begin
    for (int k = 0; k < 4; k++) begin m_reg[k] = 0; m_act[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    cur_req = "R1";
    for (int a = 0; a < 4; a++) read_chk(a, "R1");
    tick(0, 0, 0, 0);

    // R2: write and read back
    cur_req = "R2";
    write4(8'h01, 8'h80, 8'h5A, 8'hC3);
    for (int a = 0; a < 4; a++) read_chk(a, "R2");

    // R4: 32-slot format with several masks
    cur_req = "R4";
    mode_t1 = 1'b0;
    run_frame(256);
    write4(8'hFF, 8'h00, 8'hA5, 8'h3C);
    run_frame(256);
    run_frame(256);
    write4(8'h0F, 8'hF0, 8'h81, 8'h7E);
    run_frame(256);

    // R3: walking one through every channel position
    cur_req = "R3";
    for (int c = 0; c < 32; c++) begin
      write4((c / 8 == 0) ? (1 << (c % 8)) : 0, (c / 8 == 1) ? (1 << (c % 8)) : 0,
             (c / 8 == 2) ? (1 << (c % 8)) : 0, (c / 8 == 3) ? (1 << (c % 8)) : 0);
      run_frame(256);
    end

    // R9: mid-frame write and write on the frame-start edge
    cur_req = "R9";
    write4(8'h00, 8'h00, 8'h00, 8'h00);
    run_frame(256);
    for (int i = 0; i < 256; i++) tick(i == 0, i == 100, 0, 8'hFF);
    tick(1, 1, 2, 8'hFF);
    for (int i = 1; i < 256; i++) tick(0, 0, 0, 0);
    run_frame(256);

    // R5 / R6: 24-slot format, framing bit high then low
    cur_req = "R5";
    mode_t1 = 1'b1;
    write4(8'h96, 8'h3C, 8'hE1, 8'h01);
    run_frame(193);
    run_frame(193);
    cur_req = "R6";
    write4(8'hC3, 8'h55, 8'h18, 8'h00);
    run_frame(193);
    run_frame(193);
    write4(8'h00, 8'h00, 8'h00, 8'h01);
    run_frame(193);
    run_frame(193);

    // R7: upper bits of register 3 ignored in the 24-slot format
    cur_req = "R7";
    write4(8'h00, 8'h00, 8'h00, 8'hFE);
    run_frame(193);
    run_frame(193);
    write4(8'hFF, 8'hFF, 8'hFF, 8'hFE);
    run_frame(193);

    // R10: free running without sync in both formats
    cur_req = "R10";
    write4(8'h33, 8'hCC, 8'h0F, 8'h01);
    tick(1, 0, 0, 0);
    for (int i = 0; i < 3 * 193 + 40; i++) tick(0, 0, 0, 0);
    mode_t1 = 1'b0;
    tick(1, 0, 0, 0);
    for (int i = 0; i < 2 * 256 + 40; i++) tick(0, 0, 0, 0);

    // R8: early sync restarts the frame
    cur_req = "R8";
    run_frame(77);
    run_frame(133);
    run_frame(256);

    // R11: mode change in mid-frame waits for the frame start
    cur_req = "R11";
    for (int i = 0; i < 256; i++) begin
      if (i == 50) mode_t1 = 1'b1;
      tick(i == 0, 0, 0, 0);
    end
    run_frame(193);
    for (int i = 0; i < 193; i++) begin
      if (i == 20) mode_t1 = 1'b0;
      tick(i == 0, 0, 0, 0);
    end
    run_frame(256);
    tick(0, 0, 0, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule